// File: doc/BRIEF.md
# Direct-Mapped Data Cache with Selectable Write Policy

This block is a small direct-mapped data cache placed between one requester and a word-addressed memory port. Each line holds a single data word together with a tag, a valid bit and a dirty bit. The line index is the low `IDX_W` bits of the word address, and the tag is the remaining upper bits. A static mode input selects the write policy.

With `wb_mode` = 0 the cache is write-through with no allocation on a write miss. With `wb_mode` = 1 it is write-back with allocation on a write miss. A line holds exactly one word, so an allocating write miss installs the written word directly and never fetches the line from memory first.

The requester issues one read or write at a time with a valid/ready handshake, and every request completes with a one-cycle `rsp_valid` pulse. For reads, `rsp_rdata` carries the word. The memory side is a request/acknowledge port with variable latency. The request is held until a one-cycle acknowledge, and read data is taken in the acknowledge cycle.

Top module: `wpol_cache`

## Requirements
- R1: After reset `req_ready` is 1, `mem_req` and `rsp_valid` are 0, and every line is invalid, so the first access to any address misses.
- R2: In write-through mode (`wb_mode`=0), a write hit updates the cached word and also issues one memory write of the same address and data. A later read of that address returns the new word with no memory traffic.
- R3: In write-through mode, a write miss issues one memory write and leaves the cache unchanged. The word that was in the indexed line still hits, and a later read of the written address misses and fetches the word from memory.
- R4: In write-back mode (`wb_mode`=1), a write hit updates only the cached word, sets the line dirty, and issues no memory transaction.
- R5: In write-back mode, a write miss on a dirty line holding another address first writes the old word to memory at `{old tag, index}`. It then installs the new word and tag as valid and dirty.
- R6: In write-back mode, a write miss on an invalid or clean line installs the word immediately as valid and dirty, with no memory transaction.
- R7: A read miss issues a memory read of the requested address and installs the returned word as a valid, clean line. The word is then returned to the requester from the cache. A later eviction of that clean line causes no write-back.
- R8: In write-back mode, a read miss that displaces a dirty line issues the write-back of the old word before the fill read.
- R9: `req_ready` is 0 whenever `mem_req` is 1 and for the cycle after a request is accepted. Each accepted request produces exactly one one-cycle `rsp_valid` pulse.
- R10: A read hit returns the cached word and issues no memory transaction.
- R11: Once raised, `mem_req` stays high with stable `mem_addr` and `mem_we` until the cycle in which `mem_ack` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wb_mode | input | 1 | 1 = write-back with write allocate, 0 = write-through without allocate; change only when idle with no dirty lines |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Cache can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Read data, valid with `rsp_valid` for reads |
| mem_req | output | 1 | Memory transaction request, held until acknowledged |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ack | input | 1 | One-cycle acknowledge ending the transaction |
| mem_rdata | input | DATA_W | Memory read data, valid with `mem_ack` |

## Verification
The bench builds the cache with `ADDR_W`=8, `IDX_W`=3 and `DATA_W`=16. With eight lines and requests confined to a 32-word window, every index is shared by four tags. This brings clean and dirty evictions, write-back-then-fill ordering, and write misses that must leave a resident word untouched within reach of short directed sequences and of a pseudo-random mix. The memory model varies its acknowledge latency from zero to three cycles, so the hold behaviour of the memory request and the busy window on `req_ready` are exercised at several lengths.

// File: rtl/wpc_pkg.sv
package wpc_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_LOOKUP,
    S_MEMWR,
    S_EVICT,
    S_FILL,
    S_SETTLE
  } wpc_state_e;
endpackage

// File: rtl/wpc_data_ram.sv
// Single-word-per-line data store, one write port and one registered read port
module wpc_data_ram #(
  parameter int IDX_W  = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int LINES = 1 << IDX_W;

  logic [DATA_W-1:0] store [LINES];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    rdata <= store[raddr];
  end
endmodule

// File: rtl/wpc_tag_store.sv
// Per-line tag plus valid and dirty flags; flags reset, tags do not
module wpc_tag_store #(
  parameter int IDX_W = 6,
  parameter int TAG_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic             rd_dirty,
  output logic [TAG_W-1:0] rd_tag,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic             wr_dirty
);
  localparam int LINES = 1 << IDX_W;

  logic [LINES-1:0] valid_q;
  logic [LINES-1:0] dirty_q;
  logic [TAG_W-1:0] tag_q [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) begin
        valid_q[g] <= 1'b0;
        dirty_q[g] <= 1'b0;
      end else if (wr_en && wr_idx == IDX_W'(g)) begin
        valid_q[g] <= 1'b1;
        dirty_q[g] <= wr_dirty;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) tag_q[wr_idx] <= wr_tag;
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_dirty = dirty_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];
endmodule

// File: rtl/wpc_ctrl.sv
// Request sequencing: lookup, memory write, eviction, fill and re-read
module wpc_ctrl
  import wpc_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int IDX_W  = 6,
  parameter int DATA_W = 32,
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wb_mode,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [IDX_W-1:0]  ram_raddr,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic              ram_we,
  output logic [DATA_W-1:0] ram_wdata,
  output logic [IDX_W-1:0]  line_idx,
  input  logic              line_valid,
  input  logic              line_dirty,
  input  logic [TAG_W-1:0]  line_tag,
  output logic              tag_we,
  output logic [TAG_W-1:0]  tag_wdata,
  output logic              tag_wdirty
);
  wpc_state_e        st;
  logic [ADDR_W-1:0] a_q;
  logic              w_q;
  logic [DATA_W-1:0] d_q;
  logic              mem_req_q, mem_we_q, rsp_valid_q;
  logic [ADDR_W-1:0] mem_addr_q;
  logic [DATA_W-1:0] mem_wdata_q, rsp_rdata_q;

  logic [IDX_W-1:0] idx_q;
  logic [TAG_W-1:0] tagf_q;
  logic             hit, victim_dirty;

  assign idx_q        = a_q[IDX_W-1:0];
  assign tagf_q       = a_q[ADDR_W-1:IDX_W];
  assign hit          = line_valid && (line_tag == tagf_q);
  assign victim_dirty = line_valid && line_dirty;

  assign line_idx  = idx_q;
  assign ram_raddr = (st == S_IDLE) ? req_addr[IDX_W-1:0] : idx_q;
  assign req_ready = (st == S_IDLE);

  // Line updates: write hit, allocating write, fill data
  always_comb begin
    ram_we     = 1'b0;
    ram_wdata  = d_q;
    tag_we     = 1'b0;
    tag_wdata  = tagf_q;
    tag_wdirty = 1'b0;
    unique case (st)
      S_LOOKUP: begin
        if (w_q && hit) begin
          ram_we     = 1'b1;
          tag_we     = 1'b1;
          tag_wdirty = wb_mode;
        end else if (w_q && wb_mode && !victim_dirty) begin
          ram_we     = 1'b1;
          tag_we     = 1'b1;
          tag_wdirty = 1'b1;
        end
      end
      S_EVICT: begin
        if (mem_ack && w_q) begin
          ram_we     = 1'b1;
          tag_we     = 1'b1;
          tag_wdirty = 1'b1;
        end
      end
      S_FILL: begin
        if (mem_ack) begin
          ram_we    = 1'b1;
          ram_wdata = mem_rdata;
          tag_we    = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= S_IDLE;
      a_q         <= '0;
      w_q         <= 1'b0;
      d_q         <= '0;
      mem_req_q   <= 1'b0;
      mem_we_q    <= 1'b0;
      mem_addr_q  <= '0;
      mem_wdata_q <= '0;
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      rsp_valid_q <= 1'b0;
      unique case (st)
        S_IDLE: begin
          if (req_valid) begin
            a_q <= req_addr;
            w_q <= req_write;
            d_q <= req_wdata;
            st  <= S_LOOKUP;
          end
        end
        S_LOOKUP: begin
          if (!w_q) begin
            if (hit) begin
              rsp_valid_q <= 1'b1;
              rsp_rdata_q <= ram_rdata;
              st          <= S_IDLE;
            end else if (wb_mode && victim_dirty) begin
              mem_req_q   <= 1'b1;
              mem_we_q    <= 1'b1;
              mem_addr_q  <= {line_tag, idx_q};
              mem_wdata_q <= ram_rdata;
              st          <= S_EVICT;
            end else begin
              mem_req_q  <= 1'b1;
              mem_we_q   <= 1'b0;
              mem_addr_q <= a_q;
              st         <= S_FILL;
            end
          end else if (!wb_mode) begin
            mem_req_q   <= 1'b1;
            mem_we_q    <= 1'b1;
            mem_addr_q  <= a_q;
            mem_wdata_q <= d_q;
            st          <= S_MEMWR;
          end else if (hit || !victim_dirty) begin
            rsp_valid_q <= 1'b1;
            st          <= S_IDLE;
          end else begin
            mem_req_q   <= 1'b1;
            mem_we_q    <= 1'b1;
            mem_addr_q  <= {line_tag, idx_q};
            mem_wdata_q <= ram_rdata;
            st          <= S_EVICT;
          end
        end
        S_MEMWR: begin
          if (mem_ack) begin
            mem_req_q   <= 1'b0;
            rsp_valid_q <= 1'b1;
            st          <= S_IDLE;
          end
        end
        S_EVICT: begin
          if (mem_ack) begin
            if (w_q) begin
              mem_req_q   <= 1'b0;
              rsp_valid_q <= 1'b1;
              st          <= S_IDLE;
            end else begin
              mem_we_q   <= 1'b0;
              mem_addr_q <= a_q;
              st         <= S_FILL;
            end
          end
        end
        S_FILL: begin
          if (mem_ack) begin
            mem_req_q <= 1'b0;
            st        <= S_SETTLE;
          end
        end
        S_SETTLE: st <= S_LOOKUP;
        default:  st <= S_IDLE;
      endcase
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rsp_rdata_q;
  assign mem_req   = mem_req_q;
  assign mem_we    = mem_we_q;
  assign mem_addr  = mem_addr_q;
  assign mem_wdata = mem_wdata_q;
endmodule

// File: rtl/wpol_cache.sv
module wpol_cache #(
  parameter int ADDR_W = 12,
  parameter int IDX_W  = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wb_mode,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0]  ram_raddr, line_idx;
  logic [DATA_W-1:0] ram_rdata, ram_wdata;
  logic              ram_we, tag_we, tag_wdirty;
  logic              line_valid, line_dirty;
  logic [TAG_W-1:0]  line_tag, tag_wdata;

  wpc_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst(rst), .wb_mode(wb_mode),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .ram_raddr(ram_raddr), .ram_rdata(ram_rdata), .ram_we(ram_we),
    .ram_wdata(ram_wdata), .line_idx(line_idx), .line_valid(line_valid),
    .line_dirty(line_dirty), .line_tag(line_tag), .tag_we(tag_we),
    .tag_wdata(tag_wdata), .tag_wdirty(tag_wdirty)
  );

  wpc_data_ram #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_data (
    .clk(clk), .we(ram_we), .waddr(line_idx), .wdata(ram_wdata),
    .raddr(ram_raddr), .rdata(ram_rdata)
  );

  wpc_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst(rst), .rd_idx(line_idx), .rd_valid(line_valid),
    .rd_dirty(line_dirty), .rd_tag(line_tag), .wr_en(tag_we),
    .wr_idx(line_idx), .wr_tag(tag_wdata), .wr_dirty(tag_wdirty)
  );
endmodule

// File: rtl/wpc_checker.sv
module wpc_checker #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              wb_mode,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic              rsp_valid,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ack
);
  logic acc_wr, seen_mw;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_wr  <= 1'b0;
      seen_mw <= 1'b0;
    end else if (req_valid && req_ready) begin
      acc_wr  <= req_write;
      seen_mw <= 1'b0;
    end else if (mem_req && mem_we && mem_ack) begin
      seen_mw <= 1'b1;
    end
  end

  // R1
  p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (req_ready && !mem_req && !rsp_valid));
  // R9
  p_busy_not_ready_r9: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !req_ready);
  p_single_accept_r9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);
  p_rsp_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);
  // R11
  p_mem_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
  // R2, R3
  p_wt_write_to_mem_r2: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && acc_wr && !wb_mode) |-> seen_mw);
endmodule

bind wpol_cache wpc_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .wb_mode(wb_mode), .req_valid(req_valid),
  .req_ready(req_ready), .req_write(req_write), .rsp_valid(rsp_valid),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_ack(mem_ack)
);

// File: tb/sim_wpol_cache.sv
module sim_wpol_cache;
  localparam int AW = 8, IW = 3, DW = 16, LINES = 8, MSIZE = 256;

  logic clk = 1'b0, rst = 1'b1, wb_mode = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, mem_req, mem_we;
  logic [DW-1:0] rsp_rdata, mem_wdata;
  logic [AW-1:0] mem_addr;
  logic mem_ack = 1'b0;
  logic [DW-1:0] mem_rdata = '0;

  always #5 clk = ~clk;

  wpol_cache #(.ADDR_W(AW), .IDX_W(IW), .DATA_W(DW)) u0 (
    .clk(clk), .rst(rst), .wb_mode(wb_mode), .req_valid(req_valid),
    .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  int checks = 0, errors = 0, lcnt = 0;
  bit done = 0;
  string cur_tag = "R1";

  // reference model state
  bit mv [LINES];
  bit md [LINES];
  logic [AW-IW-1:0] mt [LINES];
  logic [DW-1:0] mdat [LINES];
  logic [DW-1:0] gmem [MSIZE];
  logic [DW-1:0] bmem [MSIZE];
  bit eo_we [$];
  logic [AW-1:0] eo_addr [$];
  logic [DW-1:0] eo_data [$];
  string eo_tag [$];
  bit er_wr [$];
  logic [DW-1:0] er_data [$];
  string er_tag [$];

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic push_op(bit we, logic [AW-1:0] a, logic [DW-1:0] d, string tag);
    eo_we.push_back(we); eo_addr.push_back(a); eo_data.push_back(d); eo_tag.push_back(tag);
    if (we) gmem[a] = d;
  endtask

  task automatic push_rsp(bit wr, logic [DW-1:0] d, string tag);
    er_wr.push_back(wr); er_data.push_back(d); er_tag.push_back(tag);
  endtask

  task automatic model(bit we, logic [AW-1:0] a, logic [DW-1:0] d, string tag);
    logic [IW-1:0] idx;
    logic [AW-IW-1:0] tg;
    bit hit;
    idx = a[IW-1:0];
    tg  = a[AW-1:IW];
    hit = mv[idx] && (mt[idx] == tg);
    if (!wb_mode) begin
      if (we) begin
        if (hit) mdat[idx] = d;
        push_op(1, a, d, tag);
        push_rsp(1, '0, tag);
      end else if (hit) begin
        push_rsp(0, mdat[idx], tag);
      end else begin
        push_op(0, a, '0, tag);
        mv[idx] = 1; mt[idx] = tg; md[idx] = 0; mdat[idx] = gmem[a];
        push_rsp(0, mdat[idx], tag);
      end
    end else begin
      if (!hit && mv[idx] && md[idx]) begin
        push_op(1, {mt[idx], idx}, mdat[idx], tag);
        md[idx] = 0;
      end
      if (we) begin
        mv[idx] = 1; mt[idx] = tg; md[idx] = 1; mdat[idx] = d;
        push_rsp(1, '0, tag);
      end else if (hit) begin
        push_rsp(0, mdat[idx], tag);
      end else begin
        push_op(0, a, '0, tag);
        mv[idx] = 1; mt[idx] = tg; md[idx] = 0; mdat[idx] = gmem[a];
        push_rsp(0, mdat[idx], tag);
      end
    end
  endtask

  task automatic do_req(bit we, logic [AW-1:0] a, logic [DW-1:0] d, string tag);
    cur_tag = tag;
    model(we, a, d, tag);
    @(negedge clk);
    req_valid = 1; req_write = we; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    while (er_wr.size() != 0) @(negedge clk);
  endtask

  // response and busy monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (rsp_valid) begin
        if (er_wr.size() == 0) chk(0, cur_tag, "unexpected response", 1, 0);
        else begin
          bit w;
          logic [DW-1:0] d;
          string t;
          w = er_wr.pop_front(); d = er_data.pop_front(); t = er_tag.pop_front();
          if (!w) chk(rsp_rdata === d, t, "read data", int'(rsp_rdata), int'(d));
          else chk(1, t, "write done", 0, 0);
        end
      end
      if (mem_req) chk(!req_ready, "R9", "ready while memory busy", int'(req_ready), 0);
    end
  end

  // memory model with variable latency
  initial begin
    int cnt;
    bit pend;
    cnt = 0; pend = 0;
    forever begin
      @(negedge clk);
      if (rst) begin
        mem_ack = 0; pend = 0;
      end else if (mem_ack) begin
        mem_ack = 0;
      end else if (mem_req) begin
        if (!pend) begin
          pend = 1; cnt = lcnt % 4; lcnt++;
          if (eo_we.size() == 0) chk(0, cur_tag, "unexpected memory op", int'({mem_we, mem_addr}), 0);
          else begin
            bit ew;
            logic [AW-1:0] ea;
            logic [DW-1:0] ed;
            string et;
            ew = eo_we.pop_front(); ea = eo_addr.pop_front();
            ed = eo_data.pop_front(); et = eo_tag.pop_front();
            chk(mem_we == ew && mem_addr == ea, et, "memory op kind/address",
                int'({mem_we, mem_addr}), int'({ew, ea}));
            if (ew) chk(mem_wdata === ed, et, "memory write data", int'(mem_wdata), int'(ed));
          end
        end
        if (cnt == 0) begin
          pend = 0;
          if (mem_we) bmem[mem_addr] = mem_wdata;
          else mem_rdata = bmem[mem_addr];
          mem_ack = 1;
        end else cnt--;
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog R9: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    int bad;
    for (int i = 0; i < MSIZE; i++) begin
      bmem[i] = DW'(i * 37 + 5);
      gmem[i] = bmem[i];
    end
    for (int i = 0; i < LINES; i++) begin
      mv[i] = 0; md[i] = 0; mt[i] = '0; mdat[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(req_ready == 1, "R1", "ready after reset", int'(req_ready), 1);
    chk(mem_req == 0, "R1", "mem_req after reset", int'(mem_req), 0);
    chk(rsp_valid == 0, "R1", "rsp_valid after reset", int'(rsp_valid), 0);

    // write-through phase
    do_req(0, 8'h05, '0, "R1");          // first access misses and fills
    do_req(0, 8'h05, '0, "R10");         // read hit, no traffic
    do_req(1, 8'h05, 16'hAAAA, "R2");    // write hit: cache and memory
    do_req(0, 8'h05, '0, "R2");          // new word from cache
    do_req(1, 8'h0D, 16'h1234, "R3");    // write miss: memory only
    do_req(0, 8'h05, '0, "R3");          // resident word still hits
    do_req(0, 8'h0D, '0, "R3");          // miss, fetched from memory
    do_req(1, 8'h21, 16'h5151, "R3");    // miss on invalid line
    do_req(0, 8'h21, '0, "R7");          // fill of written word

    // write-back phase (no dirty lines exist)
    wb_mode = 1;
    do_req(1, 8'h0D, 16'hBEEF, "R4");    // hit, no traffic
    do_req(0, 8'h0D, '0, "R4");
    do_req(1, 8'h15, 16'hC0DE, "R5");    // dirty victim written back
    do_req(0, 8'h15, '0, "R5");
    do_req(1, 8'h32, 16'h7777, "R6");    // invalid line, no traffic
    do_req(0, 8'h03, '0, "R7");          // clean fill
    do_req(1, 8'h0B, 16'h4242, "R6");    // clean victim, no traffic
    do_req(0, 8'h1D, '0, "R8");          // write-back then fill
    do_req(0, 8'h1D, '0, "R7");          // hit on filled line
    do_req(1, 8'h25, 16'h9999, "R7");    // clean victim: no write-back

    seed = 32'h1234_5678;
    for (int k = 0; k < 120; k++) begin
      seed = seed * 1103515245 + 12345;
      do_req(seed[20], AW'(seed[27:23]), DW'(seed[15:0]), "R5");
    end

    repeat (4) @(negedge clk);
    chk(eo_we.size() == 0, "R4", "leftover expected memory ops", eo_we.size(), 0);
    bad = 0;
    for (int i = 0; i < MSIZE; i++) if (bmem[i] !== gmem[i]) bad++;
    chk(bad == 0, "R5", "memory image mismatches", bad, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule